// File: doc/BRIEF.md
# PWM Crest/Trough Interrupt Thinning Controller

This block sits next to a complementary PWM timer and reduces how often its two periodic interrupt requests reach the processor. One source is the compare event raised at the counter crest; the other is the underflow event raised at the counter trough. Each source has its own enable bit, its own 3-bit skip count N, and its own event counter. When a source is enabled, only one raw event in every N+1 is passed on as a one-cycle interrupt pulse. When it is disabled, every raw event passes and its counter is held at zero, so clearing the enable bit is also how software restarts the count.

The pass decision of each source is also offered to two families of qualifiers. One family gates buffer-to-compare register transfers and the other gates delayed A/D converter start requests. Each qualifier has a link-select bit: while that bit is 0 the qualifier is always open; while it is 1 the qualifier opens only in the cycle its source passes an event. Configuration is only changed while both sources are idle and the enable is cleared first, so the block does not guard against changes made mid-count.

Top module: `pwm_irq_thin`

## Requirements
- R1: While `rst_n` is low, both interrupt outputs are 0 at the next clock edge and both event counters return to zero, so after reset an enabled source with skip count N passes its (N+1)th event first.
- R2: With a source enabled and its skip count 0, every raw event of that source produces an interrupt pulse.
- R3: With a source enabled and skip count N (0 to 7), the source passes its (N+1)th, 2(N+1)th, ... raw events counted since the enable bit was last 0 or since reset, and no others.
- R4: An interrupt output is high for exactly the one clock cycle following the rising clock edge that sampled the passed event, and low in every other cycle.
- R5: With a source's enable bit 0, each raw event of that source produces an interrupt pulse, and the source's counter is held at zero, so that on re-enabling counting starts afresh.
- R6: The crest source (index 0) and trough source (index 1) count and decide independently; events, settings and enable of one have no effect on the other's output.
- R7: Buffer-transfer qualifier bit k (bit 0 crest, bit 1 trough) is 1 whenever its link-select bit k is 0, and equals the interrupt output of source k when the link-select bit is 1.
- R8: A/D-start qualifier bit k (bit 0 crest, bit 1 trough) follows the same rule as R7 using its own link-select bit k.
- R9: Clock cycles with no raw event leave a source's count unchanged, so idle gaps of any length do not move the position of the next passed event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crest_evt_i | input | 1 | Raw compare event at counter crest, one cycle per event |
| trough_evt_i | input | 1 | Raw underflow event at counter trough, one cycle per event |
| crest_en_i | input | 1 | Enable skipping for the crest source; 0 clears its counter |
| trough_en_i | input | 1 | Enable skipping for the trough source; 0 clears its counter |
| crest_skip_i | input | 3 | Crest skip count N |
| trough_skip_i | input | 3 | Trough skip count N |
| xfer_link_i | input | 2 | Link buffer-transfer qualifier k to source k when 1 |
| adc_link_i | input | 2 | Link A/D-start qualifier k to source k when 1 |
| crest_irq_o | output | 1 | Thinned crest interrupt pulse |
| trough_irq_o | output | 1 | Thinned trough interrupt pulse |
| xfer_ok_o | output | 2 | Buffer-transfer qualifiers |
| adc_ok_o | output | 2 | A/D-start qualifiers |

## Verification
The bench builds the block with its default 3-bit count width, which puts every skip count from 0 through 7 within reach, including the largest count where the counter sits at its top value before wrapping. Random segments pick new skip counts, enables and link bits for both sources with a clear-then-enable sequence, so counter restart, every link combination and crest/trough interleaving are all exercised against a bench model. Directed parts cover skip count 0, skip count 7, the disabled pass-through, long idle gaps and a reset in the middle of a count.

// File: rtl/pwm_skip_pkg.sv
// Package: shared constants for the PWM interrupt thinning controller.
// Assumes index 0 is the crest source and index 1 the trough source.
package pwm_skip_pkg;
    localparam int NUM_SRC   = 2;
    localparam int SRC_CREST = 0;
    localparam int SRC_TROUGH = 1;
endpackage

// File: rtl/pwm_skip_cnt.sv
// Module: one skip channel. Counts raw events and emits a registered
// one-cycle pass pulse on every (limit+1)th event while enabled; passes
// every event and holds the count at zero while disabled.
// Assumes limit changes only while en is 0.
module pwm_skip_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    input  logic             evt,
    output logic             pass,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             pass_q;

    // Count events and decide whether the current event is passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_ZERO;
            pass_q <= 1'b0;
        end else if (!en) begin
            cnt_q  <= CNT_ZERO;
            pass_q <= evt;
        end else if (evt) begin
            if (cnt_q == limit) begin
                cnt_q  <= CNT_ZERO;
                pass_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + CNT_ONE;
                pass_q <= 1'b0;
            end
        end else begin
            pass_q <= 1'b0;
        end
    end

    assign pass = pass_q;
    assign cnt  = cnt_q;
endmodule

// File: rtl/pwm_skip_qual.sv
// Module: a bank of qualifiers. Each bit is open when its link select is
// clear, or when the linked source passes an event this cycle.
// Assumes pass is a registered single-cycle pulse per source.
module pwm_skip_qual #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] link,
    input  logic [NSRC-1:0] pass,
    output logic [NSRC-1:0] ok
);
    for (genvar k = 0; k < NSRC; k++) begin : g_bit
        // Open the qualifier unless linked and the source skips.
        always_comb begin
            ok[k] = !link[k] || pass[k];
        end
    end
endmodule

// File: rtl/pwm_irq_thin.sv
// Module: top of the PWM interrupt thinning controller. Two independent
// skip channels (crest, trough) plus buffer-transfer and A/D-start
// qualifier banks that share each channel's pass decision.
// Assumes configuration changes only with the enable cleared and no events.
module pwm_irq_thin
    import pwm_skip_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crest_evt_i,
    input  logic             trough_evt_i,
    input  logic             crest_en_i,
    input  logic             trough_en_i,
    input  logic [CNT_W-1:0] crest_skip_i,
    input  logic [CNT_W-1:0] trough_skip_i,
    input  logic [1:0]       xfer_link_i,
    input  logic [1:0]       adc_link_i,
    output logic             crest_irq_o,
    output logic             trough_irq_o,
    output logic [1:0]       xfer_ok_o,
    output logic [1:0]       adc_ok_o
);
    logic [NUM_SRC-1:0]            evt_w;
    logic [NUM_SRC-1:0]            en_w;
    logic [NUM_SRC-1:0][CNT_W-1:0] lim_w;
    logic [NUM_SRC-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_SRC-1:0]            pass_w;

    // Gather per-source inputs into indexed vectors.
    always_comb begin
        evt_w[SRC_CREST]  = crest_evt_i;
        evt_w[SRC_TROUGH] = trough_evt_i;
        en_w[SRC_CREST]   = crest_en_i;
        en_w[SRC_TROUGH]  = trough_en_i;
        lim_w[SRC_CREST]  = crest_skip_i;
        lim_w[SRC_TROUGH] = trough_skip_i;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ch
        pwm_skip_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_w[i]),
            .limit (lim_w[i]),
            .evt   (evt_w[i]),
            .pass  (pass_w[i]),
            .cnt   (cnt_w[i])
        );
    end

    pwm_skip_qual #(.NSRC(NUM_SRC)) u_xfer_q (
        .link (xfer_link_i),
        .pass (pass_w),
        .ok   (xfer_ok_o)
    );

    pwm_skip_qual #(.NSRC(NUM_SRC)) u_adc_q (
        .link (adc_link_i),
        .pass (pass_w),
        .ok   (adc_ok_o)
    );

    assign crest_irq_o  = pass_w[SRC_CREST];
    assign trough_irq_o = pass_w[SRC_TROUGH];
endmodule

// File: rtl/pwm_irq_thin_chk.sv
// Module: assertion checker bound to pwm_irq_thin. Relates raw events,
// enables, counters and outputs over time.
// Assumes skip counts are stable while a source is enabled.
module pwm_irq_thin_chk #(
    parameter int NSRC  = 2,
    parameter int CNT_W = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NSRC-1:0]            evt,
    input logic [NSRC-1:0]            en,
    input logic [NSRC-1:0][CNT_W-1:0] lim,
    input logic [NSRC-1:0][CNT_W-1:0] cnt,
    input logic [NSRC-1:0]            irq,
    input logic [NSRC-1:0]            xfer_link,
    input logic [NSRC-1:0]            xfer_ok,
    input logic [NSRC-1:0]            adc_link,
    input logic [NSRC-1:0]            adc_ok
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // R4: a pulse only follows a sampled raw event
        a_r4_pulse_after_event: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(evt[i]));
        // R2: zero skip count passes every event
        a_r2_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && lim[i] == '0 && evt[i]) |=> irq[i]);
        // R5: disabled source passes each event and holds count at zero
        a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && evt[i]) |=> irq[i]);
        a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |=> cnt[i] == '0);
        // R3: count never passes the skip count while enabled
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && $stable(lim[i])) |-> cnt[i] <= lim[i]);
        // R9: idle cycles leave the count alone
        a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && !evt[i]) |=> $stable(cnt[i]));
        // R7: a linked transfer qualifier opens only after an event
        a_r7_xfer_linked: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_link[i] && xfer_ok[i]) |-> $past(evt[i]));
        // R8: a linked A/D qualifier opens only after an event
        a_r8_adc_linked: assert property (@(posedge clk) disable iff (!rst_n)
            (adc_link[i] && adc_ok[i]) |-> $past(evt[i]));
    end
endmodule

bind pwm_irq_thin pwm_irq_thin_chk #(.NSRC(pwm_skip_pkg::NUM_SRC), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt_w),
    .en        (en_w),
    .lim       (lim_w),
    .cnt       (cnt_w),
    .irq       (pass_w),
    .xfer_link (xfer_link_i),
    .xfer_ok   (xfer_ok_o),
    .adc_link  (adc_link_i),
    .adc_ok    (adc_ok_o)
);

// File: tb/test_pwm_irq_thin.sv
// Bench: random segments plus directed corner cases against a bench model.
module test_pwm_irq_thin;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       c_evt = 1'b0, t_evt = 1'b0;
    logic       c_en = 1'b0, t_en = 1'b0;
    logic [2:0] c_skip = '0, t_skip = '0;
    logic [1:0] x_link = '0, a_link = '0;
    logic       c_irq, t_irq;
    logic [1:0] x_ok, a_ok;

    int errors = 0;
    int checks = 0;
    int m_cnt [2];
    logic m_pass [2];

    always #10 clk = ~clk;

    pwm_irq_thin i_pwm_irq_thin (
        .clk(clk), .rst_n(rst_n),
        .crest_evt_i(c_evt), .trough_evt_i(t_evt),
        .crest_en_i(c_en), .trough_en_i(t_en),
        .crest_skip_i(c_skip), .trough_skip_i(t_skip),
        .xfer_link_i(x_link), .adc_link_i(a_link),
        .crest_irq_o(c_irq), .trough_irq_o(t_irq),
        .xfer_ok_o(x_ok), .adc_ok_o(a_ok)
    );

    // Expected pass decision for one source given its pre-edge inputs.
    function automatic logic model_pass(input logic en, input int lim,
                                        input logic evt, inout int cnt);
        if (!en) begin
            cnt = 0;
            return evt;
        end
        if (!evt) return 1'b0;
        if (cnt == lim) begin
            cnt = 0;
            return 1'b1;
        end
        cnt = cnt + 1;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update model, check after the edge.
    task automatic step(input logic ce, input logic te, input string tag);
        logic [1:0] ex_irq;
        c_evt = ce;
        t_evt = te;
        if (!rst_n) begin
            m_cnt[0] = 0; m_cnt[1] = 0;
            m_pass[0] = 1'b0; m_pass[1] = 1'b0;
        end else begin
            m_pass[0] = model_pass(c_en, int'(c_skip), ce, m_cnt[0]);
            m_pass[1] = model_pass(t_en, int'(t_skip), te, m_cnt[1]);
        end
        @(posedge clk);
        @(negedge clk);
        ex_irq = {m_pass[1], m_pass[0]};
        check(tag, {t_irq, c_irq}, ex_irq);
        check("R7 xfer", x_ok, ~x_link | ex_irq);
        check("R8 adc", a_ok, ~a_link | ex_irq);
    endtask

    // Clear enables for one cycle, then load new settings and enable.
    task automatic configure(input logic ce, input logic [2:0] cs,
                             input logic te, input logic [2:0] ts);
        c_en = 1'b0; t_en = 1'b0;
        step(1'b0, 1'b0, "R5 clear");
        c_skip = cs; t_skip = ts;
        c_en = ce; t_en = te;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2718));
        @(negedge clk);
        // R1: outputs low during reset
        step(1'b1, 1'b1, "R1 reset");
        step(1'b1, 1'b1, "R1 reset");
        rst_n = 1'b1;
        // R1: after reset, skip 2 passes third event first
        c_skip = 3'd2; t_skip = 3'd2; c_en = 1'b1; t_en = 1'b1;
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1, "R1 R3 count from reset");
        // R2: skip 0 passes every event
        configure(1'b1, 3'd0, 1'b1, 3'd0);
        for (int i = 0; i < 6; i++) step(1'b1, i[0], "R2 zero skip");
        // R3 and R4: largest skip count, events back to back
        configure(1'b1, 3'd7, 1'b1, 3'd7);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R3 skip seven");
        step(1'b0, 1'b0, "R4 single pulse");
        // R5: disabled passes all events
        configure(1'b0, 3'd5, 1'b0, 3'd5);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R5 bypass");
        // R6: independence with different settings
        x_link = 2'b11; a_link = 2'b10;
        configure(1'b1, 3'd7, 1'b1, 3'd0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, "R6 independent");
        // R9: idle gaps do not move the count
        configure(1'b1, 3'd3, 1'b1, 3'd1);
        for (int j = 0; j < 4; j++) begin
            step(1'b1, 1'b1, "R9 event");
            for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R9 idle");
        end
        // R1: reset in the middle of a count
        configure(1'b1, 3'd4, 1'b1, 3'd4);
        step(1'b1, 1'b1, "R3 before reset");
        step(1'b1, 1'b1, "R3 before reset");
        rst_n = 1'b0;
        step(1'b1, 1'b1, "R1 mid reset");
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R1 restart");
        // Random segments
        for (int s = 0; s < 60; s++) begin
            x_link = 2'($urandom);
            a_link = 2'($urandom);
            configure(1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom));
            for (int i = 0; i < 40; i++)
                step(1'($urandom), 1'($urandom_range(0, 3) == 0), "R3 R6 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule